// File: doc/BRIEF.md
# Two-Wire Slave with Strapped Address

This block is the serial front end of a small peripheral on a two-wire (I2C-style) bus. It samples the bus clock and data lines with the system clock, removes short glitches, and recognises START, repeated START and STOP. The first byte after any START is a control byte. Its upper four bits must equal a fixed device code (0101). The next three bits must equal the three address strap inputs. The last bit selects the direction.

When the slave is addressed for writing, every later byte is treated as a command. The slave acknowledges each one and hands it to the attached logic with a one-cycle strobe. When it is addressed for reading, it returns the status byte from the attached logic, MSB first. It keeps sending that byte for as long as the master acknowledges. The data output is open-drain and is modelled as a pull-low enable. Each change on it is delayed a few system clocks after the filtered clock falls, which gives the master hold time.

Top module: `twi_strap_slave`

## Requirements
- R1: After reset, and before any bus activity, `sda_pull_o` and `wr_valid_o` are both 0.
- R2: A STOP (SDA rising while SCL is high) returns the slave to idle and releases SDA (`sda_pull_o`=0). The slave stays quiet until the next START.
- R3: The first byte after a START is the control byte, sent MSB first. Bits 7:4 must be 0101 and bits 3:1 must equal `strap_i[2:0]`. Bit 0 is R/W, where 1 means read. On a match the slave pulls SDA low through the whole high phase of the ninth clock. On any mismatch it leaves SDA released for the rest of that transfer, including later bytes, and produces no strobe.
- R4: In a write, any number of data bytes may follow, each received MSB first. Each byte is acknowledged on the ninth clock. During that clock it appears on `wr_data_o` together with a single-cycle `wr_valid_o` pulse.
- R5: In a read, the slave sends `status_i` MSB first. It pulls SDA low for each 0 bit and releases it for each 1 bit.
- R6: In a read, a master ACK (SDA low on the ninth clock) makes the slave send the status byte again. A master NACK makes it release SDA and stay released, even if more clocks follow, until the next START.
- R7: `sda_pull_o` changes only while the filtered SCL is low, `HOLD_CYC` system clocks after its falling edge. The only exception is the forced release on START or STOP.
- R8: A pulse on SCL or SDA lasting fewer than `FILT_CYC` system clocks is ignored. In particular, a short SDA dip while SCL is high is not taken as a START or STOP, and a short SCL dip is not taken as a clock.
- R9: A START or STOP in the middle of a byte aborts the transfer. The partial byte is never strobed out.
- R10: A repeated START ends the current transfer at once and begins address matching for a new control byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin (wired-AND level) |
| strap_i | input | 3 | Address straps compared with control-byte bits 3:1 |
| status_i | input | 8 | Byte returned on reads |
| sda_pull_o | output | 1 | 1 pulls the data line low; 0 releases it |
| wr_data_o | output | 8 | Last received command byte |
| wr_valid_o | output | 1 | One-cycle strobe marking a new byte on `wr_data_o` |

## Verification
The assertions assume that the master changes SDA only while SCL is low, except when it forms START and STOP. They also assume that each SCL phase lasts far longer than the filter and hold delays together. Under these conditions a pull change can never meet a high clock, and START/STOP can never coincide with the slave holding SDA low. The bench master keeps 30-cycle clock phases and moves SDA 10 cycles into the low phase. It separates a STOP or repeated START from the preceding SCL fall by 20 cycles, so the slave's delayed release always lands first. The deliberate glitches are 3 cycles long, which is below the filter length.

// File: rtl/twi_pkg.sv
package twi_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } twi_state_e;

  localparam logic [3:0] DEV_CODE = 4'b0101;
  localparam int unsigned BYTE_W  = 8;
endpackage

// File: rtl/twi_line_filter.sv
module twi_line_filter #(
  parameter int unsigned FILT_CYC = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_o
);
  localparam int unsigned CW = $clog2(FILT_CYC + 1);

  logic [1:0]    meta_q;
  logic [CW-1:0] run_q;
  logic          filt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= 2'b11;
      run_q  <= '0;
      filt_q <= 1'b1;
    end else begin
      meta_q <= {meta_q[0], line_i};
      if (meta_q[1] == filt_q) begin
        run_q <= '0;
      end else if (run_q == CW'(FILT_CYC - 1)) begin
        filt_q <= meta_q[1];
        run_q  <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  assign line_o = filt_q;

  // filtered level may only move to a value the synchroniser already held
  p_filt_follows_sync_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(filt_q) |-> ($past(meta_q[1]) == filt_q));
endmodule

// File: rtl/twi_bus_events.sv
module twi_bus_events (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o,
  output logic scl_rise_o,
  output logic scl_fall_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;

  p_cond_excl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({start_o, stop_o, scl_rise_o, scl_fall_o}) <= 1);
endmodule

// File: rtl/twi_slave_fsm.sv
module twi_slave_fsm
  import twi_pkg::*;
#(
  parameter int unsigned HOLD_CYC = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                scl_i,
  input  logic                sda_i,
  input  logic                start_i,
  input  logic                stop_i,
  input  logic                scl_rise_i,
  input  logic                scl_fall_i,
  input  logic [2:0]          strap_i,
  input  logic [BYTE_W-1:0]   status_i,
  output logic                sda_pull_o,
  output logic [BYTE_W-1:0]   wr_data_o,
  output logic                wr_valid_o
);
  localparam int unsigned HW = $clog2(HOLD_CYC + 1);
  localparam int unsigned BW = $clog2(BYTE_W + 1);

  twi_state_e        state_q;
  logic [BW-1:0]     bit_q;
  logic [BYTE_W-1:0] rx_q, tx_q, wdat_q;
  logic [HW-1:0]     hold_q;
  logic              pend_q, pull_q, rw_q, mack_q, wval_q;
  logic              addr_hit;

  assign addr_hit = (rx_q[7:4] == DEV_CODE) && (rx_q[3:1] == strap_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      rx_q    <= '0;
      tx_q    <= '0;
      wdat_q  <= '0;
      hold_q  <= '0;
      pend_q  <= 1'b0;
      pull_q  <= 1'b0;
      rw_q    <= 1'b0;
      mack_q  <= 1'b0;
      wval_q  <= 1'b0;
    end else begin
      wval_q <= 1'b0;
      if (hold_q != '0) begin
        hold_q <= hold_q - 1'b1;
        if (hold_q == HW'(1)) pull_q <= pend_q;
      end
      if (start_i) begin
        state_q <= ST_ADDR;
        bit_q   <= '0;
        pull_q  <= 1'b0;
        hold_q  <= '0;
      end else if (stop_i) begin
        state_q <= ST_IDLE;
        pull_q  <= 1'b0;
        hold_q  <= '0;
      end else begin
        unique case (state_q)
          ST_ADDR, ST_WR: begin
            if (scl_rise_i) begin
              rx_q  <= {rx_q[BYTE_W-2:0], sda_i};
              bit_q <= bit_q + 1'b1;
            end else if (scl_fall_i && bit_q == BW'(BYTE_W)) begin
              bit_q <= '0;
              if (state_q == ST_WR) begin
                state_q <= ST_WR_ACK;
                pend_q  <= 1'b1;
                hold_q  <= HW'(HOLD_CYC);
              end else if (addr_hit) begin
                state_q <= ST_ADDR_ACK;
                rw_q    <= rx_q[0];
                pend_q  <= 1'b1;
                hold_q  <= HW'(HOLD_CYC);
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall_i) begin
              hold_q <= HW'(HOLD_CYC);
              if (rw_q) begin
                state_q <= ST_RD;
                tx_q    <= {status_i[BYTE_W-2:0], 1'b0};
                pend_q  <= ~status_i[BYTE_W-1];
              end else begin
                state_q <= ST_WR;
                pend_q  <= 1'b0;
              end
            end
          end
          ST_WR_ACK: begin
            if (scl_rise_i) begin
              wval_q <= 1'b1;
              wdat_q <= rx_q;
            end else if (scl_fall_i) begin
              state_q <= ST_WR;
              pend_q  <= 1'b0;
              hold_q  <= HW'(HOLD_CYC);
            end
          end
          ST_RD: begin
            if (scl_rise_i) begin
              bit_q <= bit_q + 1'b1;
            end else if (scl_fall_i) begin
              hold_q <= HW'(HOLD_CYC);
              if (bit_q == BW'(BYTE_W)) begin
                bit_q   <= '0;
                state_q <= ST_RD_ACK;
                pend_q  <= 1'b0;
              end else begin
                pend_q <= ~tx_q[BYTE_W-1];
                tx_q   <= {tx_q[BYTE_W-2:0], 1'b0};
              end
            end
          end
          ST_RD_ACK: begin
            if (scl_rise_i) begin
              mack_q <= ~sda_i;
            end else if (scl_fall_i) begin
              hold_q <= HW'(HOLD_CYC);
              if (mack_q) begin
                state_q <= ST_RD;
                tx_q    <= {status_i[BYTE_W-2:0], 1'b0};
                pend_q  <= ~status_i[BYTE_W-1];
              end else begin
                state_q <= ST_IDLE;
                pend_q  <= 1'b0;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_pull_o = pull_q;
  assign wr_data_o  = wdat_q;
  assign wr_valid_o = wval_q;

  p_pull_scl_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(pull_q) && !$past(start_i || stop_i)) |-> !scl_i);
  p_stop_release_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (!pull_q && state_q == ST_IDLE));
  p_rstart_addr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (!pull_q && state_q == ST_ADDR && bit_q == '0));
  p_strobe_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wval_q |=> !wval_q);
  p_strobe_in_ack_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wval_q |-> (state_q == ST_WR_ACK));
  p_idle_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && hold_q == '0) |-> !pull_q);
endmodule

// File: rtl/twi_strap_slave.sv
module twi_strap_slave #(
  parameter int unsigned FILT_CYC = 5,
  parameter int unsigned HOLD_CYC = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_i,
  input  logic [7:0] status_i,
  output logic       sda_pull_o,
  output logic [7:0] wr_data_o,
  output logic       wr_valid_o
);
  logic [1:0] raw, filt;
  logic       start, stop, scl_rise, scl_fall;

  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_flt
    twi_line_filter #(.FILT_CYC(FILT_CYC)) u_flt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .line_i (raw[g]),
      .line_o (filt[g])
    );
  end

  twi_bus_events u_evt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (filt[0]),
    .sda_i      (filt[1]),
    .start_o    (start),
    .stop_o     (stop),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall)
  );

  twi_slave_fsm #(.HOLD_CYC(HOLD_CYC)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (filt[0]),
    .sda_i      (filt[1]),
    .start_i    (start),
    .stop_i     (stop),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .strap_i    (strap_i),
    .status_i   (status_i),
    .sda_pull_o (sda_pull_o),
    .wr_data_o  (wr_data_o),
    .wr_valid_o (wr_valid_o)
  );
endmodule

// File: tb/twi_strap_slave_tb.sv
module twi_strap_slave_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1, sda_m = 1'b1;
  logic [2:0] strap = 3'b101;
  logic [7:0] status = 8'h96;
  logic       sda_pull, wr_valid;
  logic [7:0] wr_data;
  logic       sda_bus;

  int         vectors = 0, errs = 0, cycles = 0;
  logic       chk_en = 1'b0, exp_pull = 1'b0;
  string      tag = "R1";
  logic [7:0] exp_wr_q[$];

  always #5 clk = ~clk;
  assign sda_bus = sda_m & ~sda_pull;

  twi_strap_slave dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .strap_i(strap), .status_i(status),
    .sda_pull_o(sda_pull), .wr_data_o(wr_data), .wr_valid_o(wr_valid)
  );

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  endtask

  // per-clock comparison against the behavioural model
  always @(negedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errs++;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
      finish_run();
    end
    if (chk_en) begin
      vectors++;
      if (sda_pull !== exp_pull) begin
        errs++;
        $display("FAIL %s: sda_pull actual %b expected %b", tag, sda_pull, exp_pull);
      end
    end
    if (rst_n && wr_valid) begin
      vectors++;
      if (exp_wr_q.size() == 0) begin
        errs++;
        $display("FAIL %s: wr strobe actual %h expected none", tag, wr_data);
      end else begin
        logic [7:0] e;
        e = exp_wr_q.pop_front();
        if (wr_data !== e) begin
          errs++;
          $display("FAIL %s: wr_data actual %h expected %h", tag, wr_data, e);
        end
      end
    end
  end

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string t);
    vectors++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %h expected %h", t, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // glitch: 0 none, 1 SDA dip, 2 SCL dip, during the high phase
  task automatic drive_bit(input logic b, input logic ep, input int glitch);
    wait_n(10); sda_m = b;
    wait_n(20); scl_m = 1'b1;
    wait_n(3);
    if (glitch == 1) sda_m = ~b;
    if (glitch == 2) scl_m = 1'b0;
    wait_n(3);
    sda_m = b; scl_m = 1'b1;
    wait_n(8); exp_pull = ep; chk_en = 1'b1;
    wait_n(15); chk_en = 1'b0;
    wait_n(3); scl_m = 1'b0;
  endtask

  task automatic start_c();
    sda_m = 1'b1; wait_n(20);
    scl_m = 1'b1; wait_n(20);
    sda_m = 1'b0; wait_n(20);
    scl_m = 1'b0;
  endtask

  task automatic stop_c();
    sda_m = 1'b0; wait_n(20);
    scl_m = 1'b1; wait_n(20);
    sda_m = 1'b1; wait_n(30);
  endtask

  task automatic send_byte(input logic [7:0] d, input logic ack, input int gidx, input int gkind);
    for (int i = 7; i >= 0; i--) drive_bit(d[i], 1'b0, (i == gidx) ? gkind : 0);
    drive_bit(1'b1, ack, 0);
  endtask

  task automatic send_bits(input logic [7:0] d, input int n);
    for (int i = 7; i > 7 - n; i--) drive_bit(d[i], 1'b0, 0);
  endtask

  task automatic recv_byte(input logic [7:0] st, input logic mack);
    for (int i = 7; i >= 0; i--) drive_bit(1'b1, ~st[i], 0);
    drive_bit(~mack, 1'b0, 0);
  endtask

  task automatic idle_check(input string t);
    wait_n(5);
    check({7'd0, sda_pull}, 8'h00, t);
    check(exp_wr_q.size(), 0, t);
  endtask

  initial begin
    wait_n(4);
    tag = "R1";
    check({6'd0, sda_pull, wr_valid}, 8'h00, "R1 reset");
    rst_n = 1'b1;
    wait_n(10);
    check({6'd0, sda_pull, wr_valid}, 8'h00, "R1 idle");

    // R3 R4 R7: matched write, several command bytes
    tag = "R4";
    start_c();
    send_byte({4'b0101, 3'b101, 1'b0}, 1'b1, -1, 0);
    exp_wr_q.push_back(8'h3A); send_byte(8'h3A, 1'b1, -1, 0);
    exp_wr_q.push_back(8'hC5); send_byte(8'hC5, 1'b1, -1, 0);
    exp_wr_q.push_back(8'h00); send_byte(8'h00, 1'b1, -1, 0);
    stop_c();
    idle_check("R2 after write");

    // R3: strap mismatch, later bytes ignored
    tag = "R3";
    start_c();
    send_byte({4'b0101, 3'b100, 1'b0}, 1'b0, -1, 0);
    send_byte(8'h77, 1'b0, -1, 0);
    stop_c();
    idle_check("R3 strap miss");

    // R3: device code mismatch
    start_c();
    send_byte({4'b0111, 3'b101, 1'b0}, 1'b0, -1, 0);
    stop_c();
    idle_check("R3 code miss");

    // R5 R6: read, resend on ACK, release after NACK
    tag = "R5";
    start_c();
    send_byte({4'b0101, 3'b101, 1'b1}, 1'b1, -1, 0);
    recv_byte(8'h96, 1'b1);
    tag = "R6";
    recv_byte(8'h96, 1'b0);
    recv_byte(8'hFF, 1'b0);
    stop_c();
    idle_check("R6 after nack");

    // R10: write then repeated START into a read
    tag = "R10";
    status = 8'h3C;
    start_c();
    send_byte({4'b0101, 3'b101, 1'b0}, 1'b1, -1, 0);
    exp_wr_q.push_back(8'h11); send_byte(8'h11, 1'b1, -1, 0);
    start_c();
    send_byte({4'b0101, 3'b101, 1'b1}, 1'b1, -1, 0);
    recv_byte(8'h3C, 1'b0);
    stop_c();
    idle_check("R10 rstart");

    // R9: abort mid byte by START, then by STOP
    tag = "R9";
    strap = 3'b010;
    start_c();
    send_byte({4'b0101, 3'b010, 1'b0}, 1'b1, -1, 0);
    send_bits(8'hF0, 4);
    start_c();
    send_byte({4'b0101, 3'b010, 1'b0}, 1'b1, -1, 0);
    exp_wr_q.push_back(8'h55); send_byte(8'h55, 1'b1, -1, 0);
    send_bits(8'hAA, 5);
    stop_c();
    idle_check("R9 abort");

    // R8: glitches on SDA and SCL during a written byte
    tag = "R8";
    start_c();
    send_byte({4'b0101, 3'b010, 1'b0}, 1'b1, 5, 1);
    exp_wr_q.push_back(8'hA5); send_byte(8'hA5, 1'b1, 2, 2);
    exp_wr_q.push_back(8'hFF); send_byte(8'hFF, 1'b1, 0, 1);
    stop_c();
    idle_check("R8 glitch");

    finish_run();
  end
endmodule